// File: doc/BRIEF.md
# Burst Column Order Generator

This block produces, one beat per clock cycle, the column index that each data beat of an eight-beat memory burst maps to. It is set up by the starting column bits, a sequential/interleaved select, a full/chopped select and a read/write flag. A single-cycle start request launches a burst. The block then drives eight consecutive beats. With each beat it gives a 3-bit column index, a flag marking the beat as carrying meaningful data, and a flag telling the data and strobe drivers whether to stay enabled.

A chopped burst does not shorten the slot. It still fills eight beat cycles, and its second half carries either tri-stated beats (read) or don't-care beats (write). The block captures the configuration on the cycle it accepts a start, and later changes to the inputs have no effect on the burst in progress. While a slot is running, `busy_o` is high and start requests are dropped. A single-cycle `done_o` marks the last beat.

Top module: `burst_order_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every output: `busy_o`, `done_o`, `beat_valid_o` and `drive_en_o` go to 0 and `beat_idx_o` to 0. A reset in the middle of a burst ends that burst at once.
- R2: When `busy_o` is low, a high `start_i` at a rising edge is accepted. Beat 0 appears on the outputs after that edge, and beats 1 to 7 follow on the next seven cycles.
- R3: In a full sequential read (`write_i`=0, `chop_i`=0, `interleave_i`=0), beats 0 to 3 rotate upward through the four indices of the half chosen by `col_addr_i[2]`, starting at `col_addr_i[1:0]`. Beats 4 to 7 repeat the same rotation in the other half. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R4: In a full interleaved read (`interleave_i`=1), the index of beat i is `col_addr_i` XOR i. For example, start 3 gives 3,2,1,0,7,6,5,4.
- R5: In a chopped read (`chop_i`=1, `write_i`=0), beats 0 to 3 follow the selected ordering inside the half chosen by `col_addr_i[2]`. Beats 4 to 7 have `beat_valid_o`=0, `drive_en_o`=0 and index 0.
- R6: In a chopped write, `col_addr_i[1:0]` and `interleave_i` have no effect. Beats 0 to 3 give {`col_addr_i[2]`, i}. Beats 4 to 7 are don't-care, with `beat_valid_o`=0, `drive_en_o`=1 and index 0.
- R7: In a full write, `col_addr_i` and `interleave_i` have no effect, and the indices are 0,1,2,3,4,5,6,7.
- R8: Every burst, chopped or full, keeps `busy_o` high for exactly eight cycles.
- R9: `done_o` is high for one cycle, together with beat 7, and `busy_o` is low on the cycle after it.
- R10: A start request made while `busy_o` is high is ignored, including one on the last beat of the slot. A start held high is accepted at the first edge after `busy_o` falls.
- R11: The configuration is captured at the accepting edge. Changes to `col_addr_i`, `interleave_i`, `chop_i` or `write_i` during a burst do not alter its beats.
- R12: While `busy_o` is low, `beat_valid_o` and `drive_en_o` are 0 and `beat_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst launch request |
| col_addr_i | input | 3 | Starting column bits |
| interleave_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| chop_i | input | 1 | 1 = 4-beat chop inside an 8-beat slot |
| write_i | input | 1 | 1 = write burst, 0 = read burst |
| beat_idx_o | output | 3 | Column index of the current beat |
| beat_valid_o | output | 1 | Beat carries meaningful data |
| drive_en_o | output | 1 | Data/strobe drivers enabled for this beat |
| busy_o | output | 1 | Eight-beat slot in progress |
| done_o | output | 1 | Pulse on the last beat of the slot |

## Verification
The bench aims at the places where the two orderings part ways: starting addresses with A2 set (where a rotation that wraps over all eight indices instead of within one half would give 5,6,7,0 rather than 5,6,7,4), and the read/write split on chopped bursts. A design that mixed up that split would tri-state write tails, or would honour low address bits on writes. A chopped burst that ended after four beats shows up as `busy_o` and `done_o` coming too early. The bench also holds a start high across the last beat, where a design that accepted it one cycle early would lose the final beat or run two bursts together. It changes the inputs in the middle of a burst to catch logic that reads the live configuration instead of the captured one.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;
  // Slot length in beats; orderings assume a power of two of at least 4.
  localparam int unsigned SLOT_BEATS = 8;
  localparam int unsigned IDX_W      = $clog2(SLOT_BEATS);

  typedef logic [IDX_W-1:0] beat_idx_t;

  typedef struct packed {
    logic      wr;
    logic      chop;
    logic      ilv;
    beat_idx_t col;
  } burst_cfg_t;

  typedef struct packed {
    beat_idx_t idx;
    logic      valid;
    logic      drive;
  } beat_out_t;
endpackage

// File: rtl/burst_slot_ctrl.sv
module burst_slot_ctrl
  import burst_order_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  burst_cfg_t cfg_i,
  output logic       active_q,
  output beat_idx_t  cnt_q,
  output burst_cfg_t cfg_q,
  output logic       nxt_active,
  output beat_idx_t  nxt_cnt,
  output burst_cfg_t nxt_cfg
);
  localparam beat_idx_t LAST = beat_idx_t'(SLOT_BEATS - 1);

  logic accept;
  assign accept = start_i && !active_q;

  always_comb begin
    nxt_active = active_q;
    nxt_cnt    = cnt_q;
    nxt_cfg    = cfg_q;
    if (accept) begin
      nxt_active = 1'b1;
      nxt_cnt    = '0;
      nxt_cfg    = cfg_i;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        nxt_active = 1'b0;
        nxt_cnt    = '0;
      end else begin
        nxt_cnt = cnt_q + beat_idx_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cfg_q    <= '0;
    end else begin
      active_q <= nxt_active;
      cnt_q    <= nxt_cnt;
      cfg_q    <= nxt_cfg;
    end
  end

  // R2: a slot always opens on beat 0 and steps by one beat
  p_slot_open_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> cnt_q == '0);
  p_beat_step_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + beat_idx_t'(1)));
  // R10: the slot closes after its last beat even with start held
  p_slot_close_r10: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q == LAST) |=> !active_q);
  // R11: captured configuration stays put inside the slot
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q != LAST) |=> $stable(cfg_q));
endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
  import burst_order_pkg::*;
(
  input  logic       active_i,
  input  burst_cfg_t cfg_i,
  input  beat_idx_t  beat_i,
  output beat_out_t  out_o
);
  localparam int unsigned MSB = IDX_W - 1;

  logic              in_tail;
  logic [MSB-1:0]    lo_sum;
  beat_idx_t         seq_idx;
  beat_idx_t         ilv_idx;
  beat_idx_t         rd_idx;

  assign in_tail = beat_i[MSB];
  assign lo_sum  = cfg_i.col[MSB-1:0] + beat_i[MSB-1:0];
  assign seq_idx = {cfg_i.col[MSB] ^ beat_i[MSB], lo_sum};
  assign ilv_idx = cfg_i.col ^ beat_i;
  assign rd_idx  = cfg_i.ilv ? ilv_idx : seq_idx;

  always_comb begin
    out_o = '0;
    if (active_i) begin
      if (cfg_i.wr) begin
        out_o.drive = 1'b1;
        if (!cfg_i.chop) begin
          out_o.valid = 1'b1;
          out_o.idx   = beat_i;
        end else if (!in_tail) begin
          out_o.valid = 1'b1;
          out_o.idx   = {cfg_i.col[MSB], beat_i[MSB-1:0]};
        end
      end else if (!(cfg_i.chop && in_tail)) begin
        out_o.valid = 1'b1;
        out_o.drive = 1'b1;
        out_o.idx   = rd_idx;
      end
    end
  end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import burst_order_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [IDX_W-1:0] col_addr_i,
  input  logic             interleave_i,
  input  logic             chop_i,
  input  logic             write_i,
  output logic [IDX_W-1:0] beat_idx_o,
  output logic             beat_valid_o,
  output logic             drive_en_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam beat_idx_t LAST = beat_idx_t'(SLOT_BEATS - 1);

  burst_cfg_t cfg_in, cfg_q, nxt_cfg;
  beat_idx_t  cnt_q, nxt_cnt;
  logic       active_q, nxt_active;
  beat_out_t  beat_nxt;

  assign cfg_in = '{wr: write_i, chop: chop_i, ilv: interleave_i, col: col_addr_i};

  burst_slot_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_i      (cfg_in),
    .active_q   (active_q),
    .cnt_q      (cnt_q),
    .cfg_q      (cfg_q),
    .nxt_active (nxt_active),
    .nxt_cnt    (nxt_cnt),
    .nxt_cfg    (nxt_cfg)
  );

  burst_order_calc u_calc (
    .active_i (nxt_active),
    .cfg_i    (nxt_cfg),
    .beat_i   (nxt_cnt),
    .out_o    (beat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_idx_o   <= '0;
      beat_valid_o <= 1'b0;
      drive_en_o   <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      beat_idx_o   <= beat_nxt.idx;
      beat_valid_o <= beat_nxt.valid;
      drive_en_o   <= beat_nxt.drive;
      done_o       <= nxt_active && (nxt_cnt == LAST);
    end
  end

  assign busy_o = active_q;

  // R12: nothing is presented outside a slot
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!beat_valid_o && !drive_en_o && beat_idx_o == '0));
  // R9: done marks the final beat and the slot ends right after
  p_done_in_slot_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (busy_o && cnt_q == LAST));
  p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);
  // R5: a released driver never carries valid data
  p_tail_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !drive_en_o) |-> (!beat_valid_o && beat_idx_o == '0 && cfg_q.chop && !cfg_q.wr));
  // R6: writes keep drivers on for the whole slot
  p_write_drives_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cfg_q.wr) |-> drive_en_o);
  // R3: full bursts have no empty beats
  p_full_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !cfg_q.chop) |-> beat_valid_o);
  // R7: full write walks the slot in linear order
  p_write_linear_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cfg_q.wr && !cfg_q.chop) |-> beat_idx_o == cnt_q);
endmodule

// File: tb/sim_burst_order_gen.sv
module sim_burst_order_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] col_addr_i = '0;
  logic       interleave_i = 1'b0;
  logic       chop_i = 1'b0;
  logic       write_i = 1'b0;
  logic [2:0] beat_idx_o;
  logic       beat_valid_o, drive_en_o, busy_o, done_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_order_gen u0 (
    .clk (clk), .rst (rst), .start_i (start_i), .col_addr_i (col_addr_i),
    .interleave_i (interleave_i), .chop_i (chop_i), .write_i (write_i),
    .beat_idx_o (beat_idx_o), .beat_valid_o (beat_valid_o),
    .drive_en_o (drive_en_o), .busy_o (busy_o), .done_o (done_o)
  );

  // seq: one hex digit per beat, beat 0 in the top digit; masks: bit 7 = beat 0
  typedef struct packed {
    logic        wr;
    logic        ch;
    logic        il;
    logic [2:0]  col;
    logic [31:0] seq;
    logic [7:0]  vm;
    logic [7:0]  dm;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 3'd5, 32'h56741230, 8'hFF, 8'hFF},
    '{1'b0, 1'b0, 1'b0, 3'd2, 32'h23016745, 8'hFF, 8'hFF},
    '{1'b0, 1'b0, 1'b0, 3'd0, 32'h01234567, 8'hFF, 8'hFF},
    '{1'b0, 1'b0, 1'b1, 3'd3, 32'h32107654, 8'hFF, 8'hFF},
    '{1'b0, 1'b0, 1'b1, 3'd6, 32'h67452301, 8'hFF, 8'hFF},
    '{1'b0, 1'b0, 1'b1, 3'd0, 32'h01234567, 8'hFF, 8'hFF},
    '{1'b0, 1'b1, 1'b0, 3'd7, 32'h74560000, 8'hF0, 8'hF0},
    '{1'b0, 1'b1, 1'b0, 3'd1, 32'h12300000, 8'hF0, 8'hF0},
    '{1'b0, 1'b1, 1'b1, 3'd5, 32'h54760000, 8'hF0, 8'hF0},
    '{1'b0, 1'b1, 1'b1, 3'd2, 32'h23010000, 8'hF0, 8'hF0},
    '{1'b1, 1'b0, 1'b0, 3'd5, 32'h01234567, 8'hFF, 8'hFF},
    '{1'b1, 1'b0, 1'b1, 3'd6, 32'h01234567, 8'hFF, 8'hFF},
    '{1'b1, 1'b1, 1'b0, 3'd6, 32'h45670000, 8'hF0, 8'hFF},
    '{1'b1, 1'b1, 1'b1, 3'd3, 32'h01230000, 8'hF0, 8'hFF}
  };

  function automatic string req_of(vec_t v);
    if (v.wr && !v.ch) return "R7";
    if (v.wr)          return "R6";
    if (v.ch)          return "R5";
    if (v.il)          return "R4";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // call at a negedge with busy low; returns at the negedge showing beat 0
  task automatic launch(input vec_t v);
    write_i = v.wr; chop_i = v.ch; interleave_i = v.il; col_addr_i = v.col;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic check_beat(input vec_t v, input int b, input string req);
    logic [2:0] ei;
    ei = v.seq[31-4*b -: 3] & 3'h7;
    ei = v.seq[28-4*b +: 3];
    check(beat_idx_o == ei, req, $sformatf("beat %0d index", b), beat_idx_o, ei);
    check(beat_valid_o == v.vm[7-b], req, $sformatf("beat %0d valid", b), beat_valid_o, v.vm[7-b]);
    check(drive_en_o == v.dm[7-b], req, $sformatf("beat %0d drive", b), drive_en_o, v.dm[7-b]);
    check(busy_o == 1'b1, "R8", $sformatf("beat %0d busy", b), busy_o, 1);
    check(done_o == (b == 7), "R9", $sformatf("beat %0d done", b), done_o, (b == 7));
  endtask

  task automatic check_idle(input string req);
    check(busy_o == 1'b0, req, "idle busy", busy_o, 0);
    check(done_o == 1'b0, req, "idle done", done_o, 0);
    check(beat_valid_o == 1'b0, req, "idle valid", beat_valid_o, 0);
    check(drive_en_o == 1'b0, req, "idle drive", drive_en_o, 0);
    check(beat_idx_o == 3'd0, req, "idle index", beat_idx_o, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R12");

    // table walk: R2 timing, R3..R8 orderings, R9 done
    foreach (VECS[k]) begin
      launch(VECS[k]);
      for (int b = 0; b < 8; b++) begin
        if (b > 0) @(negedge clk);
        check_beat(VECS[k], b, req_of(VECS[k]));
      end
      @(negedge clk);
      check_idle("R9");
    end

    // R11: inputs changed right after acceptance have no effect
    begin
      vec_t v;
      v = '{1'b0, 1'b0, 1'b1, 3'd3, 32'h32107654, 8'hFF, 8'hFF};
      launch(v);
      write_i = 1'b1; chop_i = 1'b1; interleave_i = 1'b0; col_addr_i = 3'd6;
      for (int b = 0; b < 8; b++) begin
        if (b > 0) @(negedge clk);
        check_beat(v, b, "R11");
      end
      @(negedge clk);
      check_idle("R11");
    end

    // R10: start held from beat 2 through the last beat is ignored, then taken
    begin
      vec_t v, w;
      v = '{1'b0, 1'b0, 1'b0, 3'd1, 32'h12305674, 8'hFF, 8'hFF};
      w = '{1'b1, 1'b0, 1'b0, 3'd7, 32'h01234567, 8'hFF, 8'hFF};
      launch(v);
      for (int b = 0; b < 8; b++) begin
        if (b > 0) @(negedge clk);
        if (b == 2) begin
          write_i = w.wr; chop_i = w.ch; interleave_i = w.il; col_addr_i = w.col;
          start_i = 1'b1;
        end
        check_beat(v, b, "R10");
      end
      @(negedge clk);
      check(busy_o == 1'b0, "R10", "start on last beat ignored", busy_o, 0);
      @(negedge clk);
      start_i = 1'b0;
      for (int b = 0; b < 8; b++) begin
        if (b > 0) @(negedge clk);
        check_beat(w, b, "R10");
      end
      @(negedge clk);
      check_idle("R10");
    end

    // R1: reset in mid-burst
    begin
      vec_t v;
      v = '{1'b0, 1'b0, 1'b1, 3'd6, 32'h67452301, 8'hFF, 8'hFF};
      launch(v);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_idle("R1");
      rst = 1'b0;
      @(negedge clk);
      check_idle("R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule